// File: doc/BRIEF.md
# Starfield and Video Compositor

This block builds the 8-bit pixel word sent to a two-bit-per-channel resistor DAC. It is used once per pixel clock. It takes the raster position, the display-enable flag, both sync levels, the text-glyph bit from the renderer and a 14-bit frame counter. From these it forms a two-layer moving starfield, puts the glyph on top in a colour picked at run time, and can darken every other raster row. It blanks the colour outside the visible area and packs sync and colour into a fixed bit order.

The starfield uses no storage. Each layer lights a pixel when the low six bits of x and y, each XORed with a different slice of the frame counter, are equal. This draws diagonal streaks. Because the two layers take their slices from different counter bits, they move at different speeds, which gives a parallax look. The output word is registered, so it appears one clock after the inputs that produce it.

Top module: `video_compositor`

## Requirements
- R1: While `rst` is high, `video_o` is 8'h00 on every clock edge. It also stays 8'h00 until the first rising edge after `rst` falls.
- R2: `video_o` changes only on a rising clock edge. It reflects the inputs sampled at that edge, so the latency is one cycle.
- R3: When `de_i` is low, all six colour bits (`video_o[6:4]` and `video_o[2:0]`) are zero, whatever the glyph, star or control inputs are.
- R4: `video_o[7]` equals `hsync_i` and `video_o[3]` equals `vsync_i`, whatever the value of `de_i`.
- R5: The output bit order, from bit 7 down to bit 0, is {hsync, B[0], G[0], R[0], vsync, B[1], G[1], R[1]}. Each of R, G and B is 2 bits wide.
- R6: The fast layer is lit when (x[5:0] ^ frame[5:0]) == (y[5:0] ^ frame[11:6]). A lit fast-layer pixel without a glyph is white, with R=G=B=3.
- R7: The slow layer is lit when (x[5:0] ^ frame[7:2]) == (y[5:0] ^ frame[13:8]). A pixel lit only by the slow layer, without a glyph, is grey, with R=G=B=2.
- R8: A glyph pixel takes priority over both star layers. `palette_i` selects its colour as {R,G,B}: 0 gives {3,3,0}, 1 gives {0,3,3}, 2 gives {3,0,3} and 3 gives {0,3,0}.
- R9: When `scanline_i` is high and y[0] is 1, each colour channel is shifted right by one bit. Even rows are not changed, and the effect is off when `scanline_i` is low.
- R10: A visible pixel with no glyph and no star is black. Bits of x and y above bit 5 have no effect on colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| x_i | input | 10 | Raster column |
| y_i | input | 10 | Raster row |
| de_i | input | 1 | High inside the visible area |
| hsync_i | input | 1 | Line sync level, passed through |
| vsync_i | input | 1 | Frame sync level, passed through |
| glyph_i | input | 1 | Text glyph covers this pixel |
| frame_i | input | 14 | Free-running frame counter |
| palette_i | input | 2 | Glyph colour select (control bits [3:2]) |
| scanline_i | input | 1 | Row darkening enable (control bit 4) |
| video_o | output | 8 | Packed sync and RGB222 word |

## Verification
The checker assumes that every input is a known value and is held steady across each rising edge. It also assumes that the star tap positions are the package defaults, because it evaluates its own star predicates on those bit slices. A register in the checker keeps all checks idle until one full cycle after reset, so the one-cycle lag never compares against values from inside reset. The bench meets these assumptions: it changes inputs only on falling edges, holds reset for several cycles, and sweeps every combination of the low six x and y bits. The higher coordinate bits, de, glyph, palette and scanline are derived from the sweep indices, and the sweep repeats over several frame values.

// File: rtl/vc_pkg.sv
package vc_pkg;

    localparam int COORD_W    = 10;
    localparam int FRAME_W    = 14;
    localparam int STAR_W     = 6;
    localparam int CH_W       = 2;
    localparam int NUM_LAYERS = 2;

    // Counter slice positions for the two star layers (layer 0 fast, 1 slow)
    localparam int FAST_X_LSB = 0;
    localparam int FAST_Y_LSB = 6;
    localparam int SLOW_X_LSB = 2;
    localparam int SLOW_Y_LSB = 8;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef enum logic [1:0] {
        PAL_YELLOW  = 2'd0,
        PAL_CYAN    = 2'd1,
        PAL_MAGENTA = 2'd2,
        PAL_GREEN   = 2'd3
    } pal_e;

    typedef enum logic [1:0] {
        SRC_BG,
        SRC_SLOW,
        SRC_FAST,
        SRC_GLYPH
    } src_e;

    localparam rgb_t RGB_BLACK = rgb_t'({2'd0, 2'd0, 2'd0});
    localparam rgb_t RGB_WHITE = rgb_t'({2'd3, 2'd3, 2'd3});
    localparam rgb_t RGB_GREY  = rgb_t'({2'd2, 2'd2, 2'd2});

    function automatic rgb_t glyph_colour(pal_e sel);
        rgb_t c;
        case (sel)
            PAL_YELLOW:  c = rgb_t'({2'd3, 2'd3, 2'd0});
            PAL_CYAN:    c = rgb_t'({2'd0, 2'd3, 2'd3});
            PAL_MAGENTA: c = rgb_t'({2'd3, 2'd0, 2'd3});
            default:     c = rgb_t'({2'd0, 2'd3, 2'd0});
        endcase
        return c;
    endfunction

    function automatic rgb_t halve(rgb_t c);
        rgb_t h;
        h.r = c.r >> 1;
        h.g = c.g >> 1;
        h.b = c.b >> 1;
        return h;
    endfunction

    // Bit order is fixed by the DAC wiring: sync, low bits, sync, high bits
    function automatic logic [7:0] pack_word(logic hs, logic vs, rgb_t c);
        return {hs, c.b[0], c.g[0], c.r[0], vs, c.b[1], c.g[1], c.r[1]};
    endfunction

endpackage

// File: rtl/vc_star_layer.sv
module vc_star_layer
    import vc_pkg::*;
#(
    parameter int X_LSB = FAST_X_LSB,
    parameter int Y_LSB = FAST_Y_LSB
) (
    input  logic [STAR_W-1:0]  x_lo,
    input  logic [STAR_W-1:0]  y_lo,
    input  logic [FRAME_W-1:0] frame,
    output logic               hit
);

    logic [STAR_W-1:0] x_mix;
    logic [STAR_W-1:0] y_mix;
    logic              unused_frame;

    assign x_mix        = x_lo ^ frame[X_LSB +: STAR_W];
    assign y_mix        = y_lo ^ frame[Y_LSB +: STAR_W];
    assign hit          = (x_mix == y_mix);
    assign unused_frame = ^frame;

endmodule

// File: rtl/vc_colour_sel.sv
module vc_colour_sel
    import vc_pkg::*;
(
    input  logic                  glyph,
    input  pal_e                  pal,
    input  logic [NUM_LAYERS-1:0] star_hit,
    output rgb_t                  colour
);

    src_e src;

    // Layer 0 is the fast field and outranks the slow one
    always_comb begin
        if (glyph)            src = SRC_GLYPH;
        else if (star_hit[0]) src = SRC_FAST;
        else if (star_hit[1]) src = SRC_SLOW;
        else                  src = SRC_BG;
    end

    always_comb begin
        case (src)
            SRC_GLYPH: colour = glyph_colour(pal);
            SRC_FAST:  colour = RGB_WHITE;
            SRC_SLOW:  colour = RGB_GREY;
            default:   colour = RGB_BLACK;
        endcase
    end

endmodule

// File: rtl/vc_tone.sv
module vc_tone
    import vc_pkg::*;
(
    input  rgb_t in_c,
    input  logic de,
    input  logic odd_row,
    input  logic scan_en,
    output rgb_t out_c
);

    rgb_t shaded;

    assign shaded = (scan_en && odd_row) ? halve(in_c) : in_c;
    assign out_c  = de ? shaded : RGB_BLACK;

endmodule

// File: rtl/video_compositor.sv
module video_compositor
    import vc_pkg::*;
#(
    parameter int FAST_X = FAST_X_LSB,
    parameter int FAST_Y = FAST_Y_LSB,
    parameter int SLOW_X = SLOW_X_LSB,
    parameter int SLOW_Y = SLOW_Y_LSB
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [COORD_W-1:0] x_i,
    input  logic [COORD_W-1:0] y_i,
    input  logic               de_i,
    input  logic               hsync_i,
    input  logic               vsync_i,
    input  logic               glyph_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [1:0]         palette_i,
    input  logic               scanline_i,
    output logic [7:0]         video_o
);

    logic [NUM_LAYERS-1:0] star_hit;
    rgb_t                  base_c;
    rgb_t                  final_c;
    logic [7:0]            video_q;
    logic                  unused_coord;

    assign unused_coord = ^{x_i[COORD_W-1:STAR_W], y_i[COORD_W-1:STAR_W]};

    for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_layer
        localparam int XL = (i == 0) ? FAST_X : SLOW_X;
        localparam int YL = (i == 0) ? FAST_Y : SLOW_Y;
        vc_star_layer #(
            .X_LSB (XL),
            .Y_LSB (YL)
        ) u_layer (
            .x_lo  (x_i[STAR_W-1:0]),
            .y_lo  (y_i[STAR_W-1:0]),
            .frame (frame_i),
            .hit   (star_hit[i])
        );
    end

    vc_colour_sel u_sel (
        .glyph    (glyph_i),
        .pal      (pal_e'(palette_i)),
        .star_hit (star_hit),
        .colour   (base_c)
    );

    vc_tone u_tone (
        .in_c    (base_c),
        .de      (de_i),
        .odd_row (y_i[0]),
        .scan_en (scanline_i),
        .out_c   (final_c)
    );

    always_ff @(posedge clk) begin
        if (rst) video_q <= 8'h00;
        else     video_q <= pack_word(hsync_i, vsync_i, final_c);
    end

    assign video_o = video_q;

endmodule

// File: rtl/vc_checker.sv
module vc_checker
    import vc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [COORD_W-1:0] x_i,
    input logic [COORD_W-1:0] y_i,
    input logic               de_i,
    input logic               hsync_i,
    input logic               vsync_i,
    input logic               glyph_i,
    input logic [FRAME_W-1:0] frame_i,
    input logic [1:0]         palette_i,
    input logic               scanline_i,
    input logic [7:0]         video_o
);

    logic armed;
    logic fast_m, slow_m, dim_m;
    logic unused_chk;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assign fast_m = ((x_i[5:0] ^ frame_i[5:0]) == (y_i[5:0] ^ frame_i[11:6]));
    assign slow_m = ((x_i[5:0] ^ frame_i[7:2]) == (y_i[5:0] ^ frame_i[13:8]));
    assign dim_m  = scanline_i && y_i[0];
    assign unused_chk = ^{x_i[COORD_W-1:6], y_i[COORD_W-1:6], palette_i};

    // R3
    p_blank_black_r3: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(de_i) |-> (video_o[6:4] == 3'b000 && video_o[2:0] == 3'b000));

    // R4
    p_sync_through_r4: assert property (@(posedge clk) disable iff (rst || !armed)
        armed |-> (video_o[7] == $past(hsync_i) && video_o[3] == $past(vsync_i)));

    // R6
    p_fast_white_r6: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(de_i && !glyph_i && fast_m && !dim_m)
        |-> (video_o[6:4] == 3'b111 && video_o[2:0] == 3'b111));

    // R7
    p_slow_grey_r7: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(de_i && !glyph_i && !fast_m && slow_m && !dim_m)
        |-> (video_o[6:4] == 3'b000 && video_o[2:0] == 3'b111));

    // R8
    p_glyph_lit_r8: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(de_i && glyph_i) |-> ({video_o[6:4], video_o[2:0]} != 6'd0));

    // R9
    p_scan_dim_r9: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(dim_m) |-> (video_o[2:0] == 3'b000));

endmodule

bind video_compositor vc_checker u_vc_checker (
    .clk        (clk),
    .rst        (rst),
    .x_i        (x_i),
    .y_i        (y_i),
    .de_i       (de_i),
    .hsync_i    (hsync_i),
    .vsync_i    (vsync_i),
    .glyph_i    (glyph_i),
    .frame_i    (frame_i),
    .palette_i  (palette_i),
    .scanline_i (scanline_i),
    .video_o    (video_o)
);

// File: tb/video_compositor_test.sv
module video_compositor_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  x_i = '0;
    logic [9:0]  y_i = '0;
    logic        de_i = 1'b0;
    logic        hsync_i = 1'b0;
    logic        vsync_i = 1'b0;
    logic        glyph_i = 1'b0;
    logic [13:0] frame_i = '0;
    logic [1:0]  palette_i = '0;
    logic        scanline_i = 1'b0;
    logic [7:0]  video_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    video_compositor uut (
        .clk(clk), .rst(rst), .x_i(x_i), .y_i(y_i), .de_i(de_i),
        .hsync_i(hsync_i), .vsync_i(vsync_i), .glyph_i(glyph_i),
        .frame_i(frame_i), .palette_i(palette_i), .scanline_i(scanline_i),
        .video_o(video_o)
    );

    function automatic logic [7:0] model(logic [9:0] x, logic [9:0] y, logic de,
                                         logic hs, logic vs, logic gl,
                                         logic [13:0] fr, logic [1:0] pal, logic sc);
        logic [1:0] cr, cg, cb;
        logic fast, slow;
        fast = ((x[5:0] ^ fr[5:0]) == (y[5:0] ^ fr[11:6]));
        slow = ((x[5:0] ^ fr[7:2]) == (y[5:0] ^ fr[13:8]));
        if (gl) begin
            case (pal)
                2'd0:    begin cr = 3; cg = 3; cb = 0; end
                2'd1:    begin cr = 0; cg = 3; cb = 3; end
                2'd2:    begin cr = 3; cg = 0; cb = 3; end
                default: begin cr = 0; cg = 3; cb = 0; end
            endcase
        end else if (fast) begin cr = 3; cg = 3; cb = 3; end
        else if (slow)     begin cr = 2; cg = 2; cb = 2; end
        else               begin cr = 0; cg = 0; cb = 0; end
        if (sc && y[0]) begin cr = cr >> 1; cg = cg >> 1; cb = cb >> 1; end
        if (!de) begin cr = 0; cg = 0; cb = 0; end
        return {hs, cb[0], cg[0], cr[0], vs, cb[1], cg[1], cr[1]};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic [9:0] x, logic [9:0] y, logic de, logic hs, logic vs,
                         logic gl, logic [13:0] fr, logic [1:0] pal, logic sc);
        x_i = x; y_i = y; de_i = de; hsync_i = hs; vsync_i = vs;
        glyph_i = gl; frame_i = fr; palette_i = pal; scanline_i = sc;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Directed: drive, clock once, compare against a literal
    task automatic directed(string req, logic [9:0] x, logic [9:0] y, logic de, logic hs,
                            logic vs, logic gl, logic [13:0] fr, logic [1:0] pal,
                            logic sc, logic [7:0] exp);
        drive(x, y, de, hs, vs, gl, fr, pal, sc);
        step();
        check(req, video_o, exp);
    endtask

    initial begin
        logic [13:0] fvals [4];
        fvals = '{14'h0000, 14'h3FFF, 14'h1A5C, 14'h0F93};

        // R1: reset holds black even with busy inputs
        drive(10'd5, 10'd5, 1'b1, 1'b1, 1'b1, 1'b1, 14'h0, 2'd0, 1'b0);
        repeat (3) begin
            step();
            check("R1 in reset", video_o, 8'h00);
        end
        rst = 1'b0;
        #1 check("R1 before first edge", video_o, 8'h00);
        @(negedge clk);
        // Yellow glyph {3,3,0}, hs=1 vs=1 -> 1011_1011
        check("R1/R8 first word", video_o, 8'hBB);

        // R2: new inputs do not show until the next edge
        drive(10'd7, 10'd1, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0001, 2'd0, 1'b0);
        #1 check("R2 hold before edge", video_o, 8'hBB);
        step();
        check("R2/R10 black after edge", video_o, 8'h00);

        // R5: cyan {0,3,3}, hs=1 vs=0 -> 1110_0110
        directed("R5 cyan pack", 10'd3, 10'd9, 1'b1, 1'b1, 1'b0, 1'b1, 14'h0, 2'd1, 1'b0, 8'hE6);
        // R5: yellow {3,3,0}, hs=0 vs=1 -> 0011_1011
        directed("R5 yellow pack", 10'd3, 10'd9, 1'b1, 1'b0, 1'b1, 1'b1, 14'h0, 2'd0, 1'b0, 8'h3B);
        // R8: green {0,3,0} -> 0010_0010 ; overrides a fast star at x=y=5
        directed("R8 green over star", 10'd5, 10'd5, 1'b1, 1'b0, 1'b0, 1'b1, 14'h0, 2'd3, 1'b0, 8'h22);
        // R4: blanking keeps both syncs
        directed("R4 sync in blank", 10'd5, 10'd5, 1'b0, 1'b1, 1'b1, 1'b1, 14'h0, 2'd0, 1'b0, 8'h88);
        directed("R4 vsync only", 10'd5, 10'd5, 1'b0, 1'b0, 1'b1, 1'b0, 14'h0, 2'd0, 1'b1, 8'h08);
        // R3: blank with glyph and star present
        directed("R3 blank glyph", 10'd5, 10'd5, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0, 2'd2, 1'b0, 8'h00);
        // R6: frame=1, x=5 y=4: fast hit only -> white 0111_0111
        directed("R6 fast only", 10'd5, 10'd4, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0001, 2'd0, 1'b0, 8'h77);
        // R6: x=y=5 frame=0 hits both layers, fast wins
        directed("R6 fast over slow", 10'd5, 10'd5, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0000, 2'd0, 1'b0, 8'h77);
        // R7: frame=1, x=y=4: slow only -> grey 0000_0111
        directed("R7 slow only", 10'd4, 10'd4, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0001, 2'd0, 1'b0, 8'h07);
        // R10: upper coordinate bits ignored
        directed("R10 upper bits grey", 10'd516, 10'd68, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0001, 2'd0, 1'b0, 8'h07);
        directed("R10 upper bits black", 10'd199, 10'd129, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0001, 2'd0, 1'b0, 8'h00);
        // R9: magenta {3,0,3} on odd row halved to {1,0,1} -> 0101_0000
        directed("R9 odd row dim", 10'd20, 10'd3, 1'b1, 1'b0, 1'b0, 1'b1, 14'h0, 2'd2, 1'b1, 8'h50);
        directed("R9 even row full", 10'd20, 10'd2, 1'b1, 1'b0, 1'b0, 1'b1, 14'h0, 2'd2, 1'b1, 8'h55);
        directed("R9 disabled odd", 10'd20, 10'd3, 1'b1, 1'b0, 1'b0, 1'b1, 14'h0, 2'd2, 1'b0, 8'h55);
        // R9: white star on odd dimmed row -> {1,1,1} -> 0111_0000
        directed("R9 star dim", 10'd5, 10'd5, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0000, 2'd0, 1'b1, 8'h70);

        // Sweep over all low-order x/y pairs for several frame values
        for (int f = 0; f < 4; f++) begin
            for (int yy = 0; yy < 64; yy++) begin
                for (int xx = 0; xx < 64; xx++) begin
                    logic [9:0] x, y;
                    logic de, gl, sc, hs, vs, fast, slow;
                    logic [1:0] pal;
                    string tag;
                    x   = 10'(xx + 64 * ((yy + f) & 15));
                    y   = 10'(yy + 64 * ((xx ^ f) & 7));
                    de  = ((xx + yy + f) % 9) != 0;
                    gl  = ((xx * 3 + yy) % 13) == 0;
                    pal = 2'(((xx >> 3) & 3) ^ f);
                    sc  = 1'(f ^ (yy >> 3));
                    hs  = 1'(xx >> 2);
                    vs  = 1'(yy >> 1);
                    fast = ((x[5:0] ^ fvals[f][5:0]) == (y[5:0] ^ fvals[f][11:6]));
                    slow = ((x[5:0] ^ fvals[f][7:2]) == (y[5:0] ^ fvals[f][13:8]));
                    if (!de)               tag = "R3 sweep";
                    else if (sc && y[0])   tag = "R9 sweep";
                    else if (gl)           tag = "R8 sweep";
                    else if (fast)         tag = "R6 sweep";
                    else if (slow)         tag = "R7 sweep";
                    else                   tag = "R10 sweep";
                    drive(x, y, de, hs, vs, gl, fvals[f], pal, sc);
                    step();
                    check(tag, video_o, model(x, y, de, hs, vs, gl, fvals[f], pal, sc));
                end
            end
        end

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule